// File: doc/BRIEF.md
# Banked Program Memory Address Mapper

This block sits between a small core and a program ROM larger than the core's program counter can reach. The core emits 12-bit code addresses, covering a 4 KB logical space. The upper 2 KB of that space always lands on one fixed 2 KB physical page. The lower 2 KB is redirected to any of several 2 KB physical pages, chosen by a bank register. With the default ten pages, the physical ROM spans 20 KB.

A second path serves constant and table reads from data space. A data read whose address falls in a 64-byte window is steered into ROM at the 64-byte segment named by a window register. The bank register and the window register are written through the same data port as ordinary stores at two fixed data addresses.

The ROM has a single port. A code fetch takes precedence over a window read. A window read that loses arbitration is held and served in the next cycle, and that cycle is withheld from the code side. The ROM returns data one cycle after it is addressed.

Top module: `bank_rom_mapper`

## Requirements
- R1: After reset the bank register and the window register are zero, `bank_err_o` is 0, and neither `code_valid_o` nor `dat_ack_o` is asserted.
- R2: A granted code fetch with logical address bit 11 set (0x800–0xFFF) drives `rom_addr_o` = FIXED_PAGE·0x800 + address[10:0], whatever the bank register holds. With the default FIXED_PAGE of 1 this is the identity mapping.
- R3: A granted code fetch with bit 11 clear (0x000–0x7FF) drives `rom_addr_o` = bank·0x800 + address[10:0].
- R4: A bank write whose value is 10 or more (NUM_PAGES or more) stores page 9 (NUM_PAGES−1) and sets `bank_err_o`. A later in-range bank write clears `bank_err_o`.
- R5: A data write to address 0xE8 loads the bank register from `dat_wdata_i[3:0]`, and bits 7:4 are ignored. A data write to address 0xE9 loads the 8-bit window register.
- R6: A data read at 0x40+n, with n from 0 to 63, drives `rom_addr_o` = window·64 + n in the same cycle. In the next cycle `dat_ack_o` is 1 and `dat_rdata_o` holds that ROM byte.
- R7: A data read outside 0x40–0x7F, or a data write inside that window, issues no ROM request and produces no `dat_ack_o`.
- R8: A register write in cycle t governs every access from cycle t+1 onward.
- R9: When a code fetch and a window read arrive in the same cycle, the code fetch is granted. In the following cycle the window read is served on the ROM, and `code_gnt_o` is 0 even if a code request is present. `dat_ack_o` rises in the cycle after that.
- R10: `code_valid_o` is 1 exactly one cycle after a cycle with `code_gnt_o` = 1, and `code_rdata_o` then holds the ROM byte fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_req_i | input | 1 | Code fetch request |
| code_addr_i | input | 12 | Logical code address |
| code_gnt_o | output | 1 | Code fetch accepted this cycle |
| code_valid_o | output | 1 | Code data valid |
| code_rdata_o | output | 8 | Code data |
| dat_req_i | input | 1 | Data-space access request |
| dat_we_i | input | 1 | Data-space write enable |
| dat_addr_i | input | 8 | Data-space address |
| dat_wdata_i | input | 8 | Data-space write data |
| dat_ack_o | output | 1 | Window read data valid |
| dat_rdata_o | output | 8 | Window read data |
| bank_err_o | output | 1 | Last bank write was out of range and was clamped |
| rom_req_o | output | 1 | ROM read request |
| rom_addr_o | output | 15 | Physical ROM address |
| rom_rdata_i | input | 8 | ROM data, one cycle after address |

## Verification
The bench builds the mapper with its default parameters: ten 2 KB pages, a 4-bit bank register, a fixed page of 1, and the window at 0x40. Because the bank register can hold values up to 15 but only ten pages exist, the bank values 10 to 15 exercise the clamp and the error flag. Because the data byte is wider than the bank register, writes with nonzero upper bits show that those bits are ignored. The 8-bit window register reaches segment 0xFF, so the top window offset lands at physical 0x3FFF. Holding a code request through the cycle after a collision shows that the code port is stalled while the held window read is served.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_CODE = 2'd1,
    SRC_WIN  = 2'd2
  } rom_src_e;
endpackage

// File: rtl/bmap_regs.sv
module bmap_regs #(
  parameter int unsigned DAW       = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned BANK_W    = 4,
  parameter int unsigned NUM_PAGES = 10,
  parameter logic [DAW-1:0] BANK_ADDR = 8'hE8,
  parameter logic [DAW-1:0] WSEL_ADDR = 8'hE9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DAW-1:0]    addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [DW-1:0]     wsel_o,
  output logic              err_o
);
  localparam logic [BANK_W-1:0] LAST_PAGE = BANK_W'(NUM_PAGES - 1);

  logic [BANK_W-1:0] raw;
  logic              over;

  assign raw  = wdata_i[BANK_W-1:0];
  assign over = int'({1'b0, raw}) >= int'(NUM_PAGES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= '0;
      err_o  <= 1'b0;
      wsel_o <= '0;
    end else if (wr_i) begin
      if (addr_i == BANK_ADDR) begin
        bank_o <= over ? LAST_PAGE : raw;
        err_o  <= over;
      end
      if (addr_i == WSEL_ADDR) wsel_o <= wdata_i;
    end
  end
endmodule

// File: rtl/bmap_xlate.sv
module bmap_xlate #(
  parameter int unsigned LOG_AW     = 12,
  parameter int unsigned PAGE_AW    = 11,
  parameter int unsigned PHYS_AW    = 15,
  parameter int unsigned BANK_W     = 4,
  parameter int unsigned FIXED_PAGE = 1,
  parameter int unsigned WIN_AW     = 6,
  parameter int unsigned DW         = 8
) (
  input  logic [LOG_AW-1:0]  code_addr_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [WIN_AW-1:0]  win_off_i,
  input  logic [DW-1:0]      wsel_i,
  output logic [PHYS_AW-1:0] code_phys_o,
  output logic [PHYS_AW-1:0] win_phys_o
);
  localparam int unsigned PG_W  = PHYS_AW - PAGE_AW;
  localparam int unsigned WIN_W = DW + WIN_AW;

  logic [PG_W-1:0] page;

  // Top bit of the logical address picks the fixed half
  assign page = code_addr_i[LOG_AW-1] ? PG_W'(FIXED_PAGE) : PG_W'(bank_i);
  assign code_phys_o = {page, code_addr_i[PAGE_AW-1:0]};

  if (PHYS_AW > WIN_W) begin : g_win_ext
    assign win_phys_o = {{(PHYS_AW-WIN_W){1'b0}}, wsel_i, win_off_i};
  end else begin : g_win_cut
    logic [WIN_W-1:0] full;
    assign full       = {wsel_i, win_off_i};
    assign win_phys_o = full[PHYS_AW-1:0];
  end
endmodule

// File: rtl/bmap_arb.sv
module bmap_arb
  import bmap_pkg::*;
#(
  parameter int unsigned PHYS_AW = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               code_req_i,
  input  logic [PHYS_AW-1:0] code_phys_i,
  input  logic               win_req_i,
  input  logic [PHYS_AW-1:0] win_phys_i,
  output logic               code_gnt_o,
  output rom_src_e           src_o,
  output logic               rom_req_o,
  output logic [PHYS_AW-1:0] rom_addr_o
);
  logic               pend_q;
  logic [PHYS_AW-1:0] pend_addr_q;
  logic               park;

  // Held window read > code fetch > fresh window read
  always_comb begin
    code_gnt_o = 1'b0;
    park       = 1'b0;
    src_o      = SRC_IDLE;
    rom_addr_o = '0;
    if (pend_q) begin
      src_o      = SRC_WIN;
      rom_addr_o = pend_addr_q;
    end else if (code_req_i) begin
      code_gnt_o = 1'b1;
      src_o      = SRC_CODE;
      rom_addr_o = code_phys_i;
      park       = win_req_i;
    end else if (win_req_i) begin
      src_o      = SRC_WIN;
      rom_addr_o = win_phys_i;
    end
  end

  assign rom_req_o = src_o != SRC_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      pend_q <= park;
      if (park) pend_addr_q <= win_phys_i;
    end
  end
endmodule

// File: rtl/bank_rom_mapper.sv
module bank_rom_mapper
  import bmap_pkg::*;
#(
  parameter int unsigned LOG_AW     = 12,
  parameter int unsigned PAGE_AW    = 11,
  parameter int unsigned PHYS_AW    = 15,
  parameter int unsigned BANK_W     = 4,
  parameter int unsigned NUM_PAGES  = 10,
  parameter int unsigned FIXED_PAGE = 1,
  parameter int unsigned WIN_AW     = 6,
  parameter int unsigned DAW        = 8,
  parameter int unsigned DW         = 8,
  parameter logic [DAW-1:0] WIN_BASE  = 8'h40,
  parameter logic [DAW-1:0] BANK_ADDR = 8'hE8,
  parameter logic [DAW-1:0] WSEL_ADDR = 8'hE9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               code_req_i,
  input  logic [LOG_AW-1:0]  code_addr_i,
  output logic               code_gnt_o,
  output logic               code_valid_o,
  output logic [DW-1:0]      code_rdata_o,
  input  logic               dat_req_i,
  input  logic               dat_we_i,
  input  logic [DAW-1:0]     dat_addr_i,
  input  logic [DW-1:0]      dat_wdata_i,
  output logic               dat_ack_o,
  output logic [DW-1:0]      dat_rdata_o,
  output logic               bank_err_o,
  output logic               rom_req_o,
  output logic [PHYS_AW-1:0] rom_addr_o,
  input  logic [DW-1:0]      rom_rdata_i
);
  logic [BANK_W-1:0]  bank;
  logic [DW-1:0]      wsel;
  logic [PHYS_AW-1:0] code_phys, win_phys;
  logic               in_win, win_rd, reg_wr;
  rom_src_e           src, src_q;

  assign in_win = dat_addr_i[DAW-1:WIN_AW] == WIN_BASE[DAW-1:WIN_AW];
  assign win_rd = dat_req_i && !dat_we_i && in_win;
  assign reg_wr = dat_req_i && dat_we_i;

  bmap_regs #(
    .DAW(DAW), .DW(DW), .BANK_W(BANK_W), .NUM_PAGES(NUM_PAGES),
    .BANK_ADDR(BANK_ADDR), .WSEL_ADDR(WSEL_ADDR)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr), .addr_i(dat_addr_i), .wdata_i(dat_wdata_i),
    .bank_o(bank), .wsel_o(wsel), .err_o(bank_err_o)
  );

  bmap_xlate #(
    .LOG_AW(LOG_AW), .PAGE_AW(PAGE_AW), .PHYS_AW(PHYS_AW), .BANK_W(BANK_W),
    .FIXED_PAGE(FIXED_PAGE), .WIN_AW(WIN_AW), .DW(DW)
  ) u_xlate (
    .code_addr_i, .bank_i(bank), .win_off_i(dat_addr_i[WIN_AW-1:0]),
    .wsel_i(wsel), .code_phys_o(code_phys), .win_phys_o(win_phys)
  );

  bmap_arb #(.PHYS_AW(PHYS_AW)) u_arb (
    .clk_i, .rst_ni,
    .code_req_i, .code_phys_i(code_phys),
    .win_req_i(win_rd), .win_phys_i(win_phys),
    .code_gnt_o, .src_o(src), .rom_req_o, .rom_addr_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_IDLE;
    else         src_q <= src;
  end

  assign code_valid_o = src_q == SRC_CODE;
  assign dat_ack_o    = src_q == SRC_WIN;
  assign code_rdata_o = rom_rdata_i;
  assign dat_rdata_o  = rom_rdata_i;
endmodule

// File: rtl/bmap_chk.sv
module bmap_chk #(
  parameter int unsigned LOG_AW     = 12,
  parameter int unsigned PAGE_AW    = 11,
  parameter int unsigned PHYS_AW    = 15,
  parameter int unsigned BANK_W     = 4,
  parameter int unsigned NUM_PAGES  = 10,
  parameter int unsigned FIXED_PAGE = 1,
  parameter int unsigned WIN_AW     = 6,
  parameter int unsigned DAW        = 8,
  parameter int unsigned DW         = 8,
  parameter logic [DAW-1:0] WIN_BASE  = 8'h40,
  parameter logic [DAW-1:0] BANK_ADDR = 8'hE8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               code_req_i,
  input logic [LOG_AW-1:0]  code_addr_i,
  input logic               code_gnt_o,
  input logic               code_valid_o,
  input logic               dat_req_i,
  input logic               dat_we_i,
  input logic [DAW-1:0]     dat_addr_i,
  input logic [DW-1:0]      dat_wdata_i,
  input logic               dat_ack_o,
  input logic               bank_err_o,
  input logic               rom_req_o,
  input logic [PHYS_AW-1:0] rom_addr_o
);
  localparam int unsigned PG_W = PHYS_AW - PAGE_AW;

  logic win_rd, bank_wr, bank_over;
  assign win_rd    = dat_req_i && !dat_we_i && (dat_addr_i[DAW-1:WIN_AW] == WIN_BASE[DAW-1:WIN_AW]);
  assign bank_wr   = dat_req_i && dat_we_i && dat_addr_i == BANK_ADDR;
  assign bank_over = int'({1'b0, dat_wdata_i[BANK_W-1:0]}) >= int'(NUM_PAGES);

  // R2
  fixed_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_gnt_o && code_addr_i[LOG_AW-1]) |-> rom_addr_o[PHYS_AW-1:PAGE_AW] == PG_W'(FIXED_PAGE));

  // R4
  page_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_gnt_o && !code_addr_i[LOG_AW-1]) |-> int'(rom_addr_o[PHYS_AW-1:PAGE_AW]) < int'(NUM_PAGES));

  // R4
  clamp_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_wr && bank_over) |=> bank_err_o);

  // R8
  bank_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bank_wr && !bank_over) ##1 (code_gnt_o && !code_addr_i[LOG_AW-1]))
      |-> rom_addr_o[PHYS_AW-1:PAGE_AW] == PG_W'($past(dat_wdata_i[BANK_W-1:0])));

  // R9
  code_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_req_i && win_rd) |-> code_gnt_o);

  // R9
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_req_i && win_rd) |=> (!code_gnt_o && rom_req_o) ##1 dat_ack_o);

  // R10
  code_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_gnt_o |=> code_valid_o);

  // R7
  no_stray_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_req_o) |=> !dat_ack_o && !code_valid_o);

  // R10
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(code_valid_o && dat_ack_o));
endmodule

bind bank_rom_mapper bmap_chk #(
  .LOG_AW(LOG_AW), .PAGE_AW(PAGE_AW), .PHYS_AW(PHYS_AW), .BANK_W(BANK_W),
  .NUM_PAGES(NUM_PAGES), .FIXED_PAGE(FIXED_PAGE), .WIN_AW(WIN_AW),
  .DAW(DAW), .DW(DW), .WIN_BASE(WIN_BASE), .BANK_ADDR(BANK_ADDR)
) u_chk (
  .clk_i, .rst_ni, .code_req_i, .code_addr_i, .code_gnt_o, .code_valid_o,
  .dat_req_i, .dat_we_i, .dat_addr_i, .dat_wdata_i, .dat_ack_o,
  .bank_err_o, .rom_req_o, .rom_addr_o
);

// File: tb/sim_bank_rom_mapper.sv
module sim_bank_rom_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        code_req_i = 1'b0;
  logic [11:0] code_addr_i = '0;
  logic        code_gnt_o, code_valid_o;
  logic [7:0]  code_rdata_o;
  logic        dat_req_i = 1'b0, dat_we_i = 1'b0;
  logic [7:0]  dat_addr_i = '0, dat_wdata_i = '0;
  logic        dat_ack_o;
  logic [7:0]  dat_rdata_o;
  logic        bank_err_o, rom_req_o;
  logic [14:0] rom_addr_o;
  logic [7:0]  rom_q = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bank_rom_mapper u0 (
    .clk_i, .rst_ni, .code_req_i, .code_addr_i, .code_gnt_o, .code_valid_o,
    .code_rdata_o, .dat_req_i, .dat_we_i, .dat_addr_i, .dat_wdata_i,
    .dat_ack_o, .dat_rdata_o, .bank_err_o, .rom_req_o, .rom_addr_o,
    .rom_rdata_i(rom_q)
  );

  function automatic logic [7:0] rom_fn(input logic [14:0] a);
    return a[7:0] + 8'(a[14:8] * 8'd13);
  endfunction

  always_ff @(posedge clk_i) rom_q <= rom_fn(rom_addr_o);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    code_req_i = 1'b0;
    dat_req_i  = 1'b0;
    dat_we_i   = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    idle();
    dat_req_i = 1'b1; dat_we_i = 1'b1; dat_addr_i = a; dat_wdata_i = d;
    @(negedge clk_i);
    idle();
  endtask

  // Called at a negedge; leaves the bench one negedge later
  task automatic fetch(input logic [11:0] a, input logic [14:0] exp, input string req);
    code_req_i = 1'b1; code_addr_i = a;
    #1;
    chk(code_gnt_o && rom_addr_o == exp, req, rom_addr_o, exp);
    @(negedge clk_i);
    idle();
    chk(code_valid_o && code_rdata_o == rom_fn(exp), {req, " R10"}, code_rdata_o, rom_fn(exp));
  endtask

  task automatic wread(input logic [7:0] a, input logic [14:0] exp, input string req);
    dat_req_i = 1'b1; dat_we_i = 1'b0; dat_addr_i = a;
    #1;
    chk(rom_req_o && rom_addr_o == exp, req, rom_addr_o, exp);
    @(negedge clk_i);
    idle();
    chk(dat_ack_o && dat_rdata_o == rom_fn(exp), req, dat_rdata_o, rom_fn(exp));
  endtask

  // {bank write data, logical address, expected physical, expected error flag}
  localparam int NV = 9;
  localparam logic [35:0] VEC [NV] = '{
    {8'h00, 12'h123, 15'h0123, 1'b0},
    {8'h03, 12'h7FF, 15'h1FFF, 1'b0},
    {8'h09, 12'h000, 15'h4800, 1'b0},
    {8'h05, 12'h800, 15'h0800, 1'b0},
    {8'h05, 12'hFFF, 15'h0FFF, 1'b0},
    {8'h0C, 12'h010, 15'h4810, 1'b1},
    {8'hF7, 12'h400, 15'h3C00, 1'b0},
    {8'h1A, 12'h7FE, 15'h4FFE, 1'b1},
    {8'h12, 12'h456, 15'h1456, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(!bank_err_o && !code_valid_o && !dat_ack_o, "R1 reset outputs",
        {bank_err_o, code_valid_o, dat_ack_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    fetch(12'h100, 15'h0100, "R1 bank zero");
    wread(8'h40, 15'h0000, "R1 window zero");

    // R2 R3 R4 R5 R8: table walk, fetch in the cycle after each bank write
    for (int i = 0; i < NV; i++) begin
      wr(8'hE8, VEC[i][35:28]);
      chk(bank_err_o == VEC[i][0], "R4 error flag", bank_err_o, VEC[i][0]);
      fetch(VEC[i][27:16], VEC[i][15:1], "R3 R2 R5 R8 mapped fetch");
    end

    // R6 R5: window reads
    wr(8'hE9, 8'h05);
    wread(8'h4A, 15'h014A, "R6 window offset 10");
    wr(8'hE9, 8'hFF);
    wread(8'h7F, 15'h3FFF, "R6 window top");

    // R7: read outside window, write inside window
    dat_req_i = 1'b1; dat_we_i = 1'b0; dat_addr_i = 8'h80;
    #1 chk(!rom_req_o, "R7 read outside window", rom_req_o, 0);
    @(negedge clk_i); idle();
    chk(!dat_ack_o, "R7 no ack outside", dat_ack_o, 0);
    dat_req_i = 1'b1; dat_we_i = 1'b1; dat_addr_i = 8'h45; dat_wdata_i = 8'h33;
    #1 chk(!rom_req_o, "R7 write into window", rom_req_o, 0);
    @(negedge clk_i); idle();
    chk(!dat_ack_o, "R7 no ack on write", dat_ack_o, 0);
    wread(8'h7F, 15'h3FFF, "R7 window reg unchanged");

    // R9: collision, code held high through the stall
    code_req_i = 1'b1; code_addr_i = 12'h900;
    dat_req_i = 1'b1; dat_we_i = 1'b0; dat_addr_i = 8'h41;
    #1 chk(code_gnt_o && rom_addr_o == 15'h0900, "R9 code first", rom_addr_o, 15'h0900);
    @(negedge clk_i);
    dat_req_i = 1'b0; code_addr_i = 12'h901;
    chk(code_valid_o && code_rdata_o == rom_fn(15'h0900), "R9 R10 code data", code_rdata_o, rom_fn(15'h0900));
    #1 chk(!code_gnt_o && rom_addr_o == 15'h3FC1, "R9 held window served", rom_addr_o, 15'h3FC1);
    @(negedge clk_i);
    chk(dat_ack_o && dat_rdata_o == rom_fn(15'h3FC1), "R9 window ack", dat_rdata_o, rom_fn(15'h3FC1));
    #1 chk(code_gnt_o && rom_addr_o == 15'h0901, "R9 code resumes", rom_addr_o, 15'h0901);
    @(negedge clk_i); idle();
    chk(code_valid_o && code_rdata_o == rom_fn(15'h0901), "R9 resumed data", code_rdata_o, rom_fn(15'h0901));

    // R1: reset in mid-run with error flag set
    wr(8'hE8, 8'h0F);
    wr(8'hE9, 8'h22);
    rst_ni = 1'b0;
    #1 chk(!bank_err_o, "R1 reset clears error", bank_err_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    fetch(12'h055, 15'h0055, "R1 bank cleared");
    wread(8'h43, 15'h0003, "R1 window cleared");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule